// File: doc/BRIEF.md
# Dual-Lane Saturating Arithmetic Shifter

The block treats a 32-bit operand as two signed 16-bit lanes and applies one arithmetic shift to each lane separately. No bits pass between the lanes. The shift distance is a signed count. A positive count shifts left, and any lane whose exact result no longer fits in 16 signed bits is clamped to the nearest representable extreme. A negative count shifts right and fills from the sign bit. The two lane results are packed back into a 32-bit word and registered, so they appear one clock after the inputs are sampled. Each lane also reports a flag for every operation in which it was clamped.

The block serves as the vector-shift leg of a fixed-point datapath. It sits between operand fetch and writeback, and it takes a new operation every cycle.

Top module: `dls_shifter`

## Requirements
- R1: The upper lane is `operand_i[31:16]` and the lower lane is `operand_i[15:0]`. Each lane's result is shifted on its own, with no bits crossing between lanes. The result is placed at the same bit position in `result_o` and is registered, so it appears after the first rising clock edge that samples the inputs.
- R2: The shift count is the two's-complement value in `count_i[5:0]`, with a range of -32 to +31. `count_i[15:6]` has no effect on the result or the flags.
- R3: A count of zero returns the operand unchanged and clears both flags.
- R4: A left shift by n whose exact result fits in 16 signed bits yields the lane value times 2^n, with the flag low.
- R5: A left shift whose exact result exceeds the 16-bit signed range gives 0x7FFF for a positive lane and 0x8000 for a negative lane. It also raises that lane's flag: `ovf_o[1]` for the upper lane and `ovf_o[0]` for the lower lane.
- R6: A zero lane yields zero under every count and never raises its flag.
- R7: A right shift by n is an arithmetic shift that fills from the sign bit. It never raises a flag. Shifting right by 15 or more leaves 0x0000 for a non-negative lane and 0xFFFF for a negative lane.
- R8: A left shift by 16 or more clamps every nonzero lane: positive lanes go to 0x7FFF and negative lanes go to 0x8000.
- R9: While `rst_ni` is low, `result_o` and `ovf_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| operand_i | input | 32 | Two packed signed 16-bit lanes |
| count_i | input | 16 | Signed shift count; only bits 5:0 are used |
| result_o | output | 32 | Packed shifted lanes, registered |
| ovf_o | output | 2 | Per-lane clamp flags, registered |

## Verification
The bench targets the lane boundary. A shifter that lets bits leak across lanes corrupts the lower lane's top bits, which shows up whenever the upper lane is nonzero. It also targets the clamp edges, using 0x7FFF, 0x8000, 0x4000 and 0xC000 at shifts near 1 and 15. A design that checks only the lane's top bit misses an overflow at -32768 << 1, and a design that truncates gives wrapped values with no flag. Counts of ±16 and ±32 catch a decoder that wraps the magnitude to zero and returns the operand unchanged. Counts whose upper bits are set catch a decoder that reads the wrong field. A sweep from -16 to +16 over edge lanes is checked against a reference model that uses wide signed arithmetic.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic {
    DIR_RIGHT = 1'b0,
    DIR_LEFT  = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/dls_count_decode.sv
module dls_count_decode
  import dls_pkg::*;
#(
  parameter int LANE_W   = 16,
  parameter int CNT_BITS = 6,
  localparam int AMT_W   = $clog2(LANE_W + 1)
) (
  input  logic [CNT_BITS-1:0] cnt_i,
  output shift_dir_e          dir_o,
  output logic [AMT_W-1:0]    amt_o
);
  logic                neg;
  logic [CNT_BITS-1:0] mag;

  assign neg = cnt_i[CNT_BITS-1];
  // most negative count negates onto itself; read unsigned it is the right magnitude
  assign mag = neg ? (~cnt_i + 1'b1) : cnt_i;

  always_comb begin
    dir_o = neg ? DIR_RIGHT : DIR_LEFT;
    if (int'(mag) > LANE_W) amt_o = AMT_W'(LANE_W);
    else                    amt_o = AMT_W'(mag);
  end
endmodule

// File: rtl/dls_lane.sv
module dls_lane
  import dls_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int AMT_W  = $clog2(LANE_W + 1),
  localparam int WIDE_W = 2 * LANE_W + 1
) (
  input  logic [LANE_W-1:0] lane_i,
  input  shift_dir_e        dir_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [LANE_W-1:0] lane_o,
  output logic              ovf_o
);
  logic [WIDE_W-1:0]    wide;
  logic [WIDE_W-1:0]    up;
  logic [LANE_W+1:0]    head;
  logic [LANE_W-1:0]    dn;
  logic [LANE_W-1:0]    sat;
  logic                 fits;

  assign wide = {{(LANE_W + 1){lane_i[LANE_W-1]}}, lane_i};
  assign up   = wide << amt_i;
  // result fits when every bit above the lane sign copies it
  assign head = up[WIDE_W-1:LANE_W-1];
  assign fits = (&head) | ~(|head);
  assign dn   = LANE_W'($signed(lane_i) >>> amt_i);
  assign sat  = lane_i[LANE_W-1] ? {1'b1, {(LANE_W - 1){1'b0}}}
                                 : {1'b0, {(LANE_W - 1){1'b1}}};

  always_comb begin
    if (dir_i == DIR_LEFT) begin
      lane_o = fits ? up[LANE_W-1:0] : sat;
      ovf_o  = ~fits;
    end else begin
      lane_o = dn;
      ovf_o  = 1'b0;
    end
  end
endmodule

// File: rtl/dls_shifter.sv
module dls_shifter
  import dls_pkg::*;
#(
  parameter int LANE_W   = 16,
  parameter int LANES    = 2,
  parameter int CNT_W    = 16,
  parameter int CNT_BITS = 6,
  localparam int DATA_W  = LANE_W * LANES,
  localparam int AMT_W   = $clog2(LANE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] result_o,
  output logic [LANES-1:0]  ovf_o
);
  shift_dir_e        dir;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] res_d;
  logic [LANES-1:0]  ovf_d;
  logic              unused_cnt_hi;

  assign unused_cnt_hi = ^count_i[CNT_W-1:CNT_BITS];

  dls_count_decode #(
    .LANE_W  (LANE_W),
    .CNT_BITS(CNT_BITS)
  ) u_dec (
    .cnt_i(count_i[CNT_BITS-1:0]),
    .dir_o(dir),
    .amt_o(amt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dls_lane #(
      .LANE_W(LANE_W)
    ) u_lane (
      .lane_i(operand_i[g*LANE_W +: LANE_W]),
      .dir_i (dir),
      .amt_i (amt),
      .lane_o(res_d[g*LANE_W +: LANE_W]),
      .ovf_o (ovf_d[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      ovf_o    <= '0;
    end else begin
      result_o <= res_d;
      ovf_o    <= ovf_d;
    end
  end
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int LANE_W   = 16,
  parameter int LANES    = 2,
  parameter int CNT_W    = 16,
  parameter int CNT_BITS = 6,
  localparam int DATA_W  = LANE_W * LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] operand_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [DATA_W-1:0] result_o,
  input logic [LANES-1:0]  ovf_o
);
  localparam logic [LANE_W-1:0] MAX_V = {1'b0, {(LANE_W - 1){1'b1}}};
  localparam logic [LANE_W-1:0] MIN_V = {1'b1, {(LANE_W - 1){1'b0}}};

  p_zero_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i[CNT_BITS-1:0] == '0) |=> (result_o == $past(operand_i)) && (ovf_o == '0));

  p_right_no_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i[CNT_BITS-1] |=> (ovf_o == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_sat_value_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o[g] |-> (result_o[g*LANE_W +: LANE_W] == MAX_V) ||
                   (result_o[g*LANE_W +: LANE_W] == MIN_V));

    p_sat_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!count_i[CNT_BITS-1]) |=>
        (!ovf_o[g] || (result_o[g*LANE_W+LANE_W-1] == $past(operand_i[g*LANE_W+LANE_W-1]))));

    p_zero_lane_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (operand_i[g*LANE_W +: LANE_W] == '0) |=>
        (result_o[g*LANE_W +: LANE_W] == '0) && !ovf_o[g]);

    p_right_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (count_i[CNT_BITS-1]) |=>
        (result_o[g*LANE_W+LANE_W-1] == $past(operand_i[g*LANE_W+LANE_W-1])));
  end
endmodule

bind dls_shifter dls_checker #(
  .LANE_W  (LANE_W),
  .LANES   (LANES),
  .CNT_W   (CNT_W),
  .CNT_BITS(CNT_BITS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .operand_i(operand_i),
  .count_i  (count_i),
  .result_o (result_o),
  .ovf_o    (ovf_o)
);

// File: tb/dls_shifter_tb.sv
module dls_shifter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] operand_i = '0;
  logic [15:0] count_i = '0;
  logic [31:0] result_o;
  logic [1:0]  ovf_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dls_shifter u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .operand_i(operand_i),
    .count_i  (count_i),
    .result_o (result_o),
    .ovf_o    (ovf_o)
  );

  function automatic logic [15:0] ref_lane(input logic [15:0] v, input int sh, output logic sat);
    longint x;
    x   = longint'($signed(v));
    sat = 1'b0;
    if (sh >= 0) begin
      x = x * (longint'(1) << sh);
      if (x > 32767) begin
        x = 32767; sat = 1'b1;
      end else if (x < -32768) begin
        x = -32768; sat = 1'b1;
      end
    end else begin
      x = x >>> (-sh);
    end
    return x[15:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at falling edge, sample at next falling edge (one register)
  task automatic run(input logic [31:0] op, input logic [15:0] cnt, input string req);
    logic [15:0] hi, lo;
    logic        sh_hi, sh_lo;
    int          sh;
    @(negedge clk);
    operand_i = op;
    count_i   = cnt;
    @(negedge clk);
    sh = int'($signed(cnt[5:0]));
    hi = ref_lane(op[31:16], sh, sh_hi);
    lo = ref_lane(op[15:0], sh, sh_lo);
    chk({req, " result"}, result_o, {hi, lo});
    chk({req, " flags"}, {30'd0, ovf_o}, {30'd0, sh_hi, sh_lo});
  endtask

  task automatic run_exp(input logic [31:0] op, input logic [15:0] cnt,
                         input logic [31:0] exp, input logic [1:0] exp_ovf, input string req);
    @(negedge clk);
    operand_i = op;
    count_i   = cnt;
    @(negedge clk);
    chk({req, " result"}, result_o, exp);
    chk({req, " flags"}, {30'd0, ovf_o}, {30'd0, exp_ovf});
  endtask

  task automatic t_reset;
    operand_i = 32'h1234_5678;
    count_i   = 16'd3;
    repeat (2) @(negedge clk);
    chk("R9 reset result", result_o, 32'h0);
    chk("R9 reset flags", {30'd0, ovf_o}, 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic t_known_values;
    run_exp(32'h0123_0002, 16'd5, 32'h2460_0040, 2'b00, "R4 left by 5");
    run_exp(32'h4567_FFFF, 16'hFFFF, 32'h22B3_FFFF, 2'b00, "R7 right by 1");
    run_exp(32'h0001_8000, 16'd15, 32'h7FFF_8000, 2'b11, "R5 shift 15");
    run_exp(32'hFFFF_0001, 16'd15, 32'h8000_7FFF, 2'b01, "R4 R5 neg fits pos clamps");
  endtask

  task automatic t_zero_count;
    run_exp(32'h8001_7FFE, 16'd0, 32'h8001_7FFE, 2'b00, "R3 zero count");
    run_exp(32'hDEAD_BEEF, 16'h0040, 32'hDEAD_BEEF, 2'b00, "R2 R3 upper bits only");
  endtask

  task automatic t_clamp_edges;
    run_exp(32'h7FFF_8000, 16'd1, 32'h7FFF_8000, 2'b11, "R5 extremes by 1");
    run_exp(32'h4000_C000, 16'd1, 32'h7FFF_8000, 2'b10, "R5 boundary by 1");
    run_exp(32'h3FFF_C001, 16'd1, 32'h7FFE_8002, 2'b00, "R4 just fits");
  endtask

  task automatic t_zero_lane;
    run_exp(32'h0000_1234, 16'd16, 32'h0000_7FFF, 2'b01, "R6 R8 zero upper by 16");
    run_exp(32'h0000_0000, 16'd31, 32'h0000_0000, 2'b00, "R6 zeros by 31");
    run_exp(32'h0001_0000, 16'd15, 32'h7FFF_0000, 2'b10, "R6 zero lower by 15");
  endtask

  task automatic t_large_counts;
    run_exp(32'h0001_FFFF, 16'd16, 32'h7FFF_8000, 2'b11, "R8 left 16");
    run_exp(32'h0001_FFFF, 16'd31, 32'h7FFF_8000, 2'b11, "R8 left 31");
    run_exp(32'h7FFF_8000, 16'hFFF0, 32'h0000_FFFF, 2'b00, "R7 right 16");
    run_exp(32'h4567_89AB, 16'hFFF1, 32'h0000_FFFF, 2'b00, "R7 right 15");
    run_exp(32'h7FFF_8000, 16'h7FE0, 32'h0000_FFFF, 2'b00, "R2 R7 right 32");
    run_exp(32'h0123_0002, 16'hFFC5, 32'h2460_0040, 2'b00, "R2 upper bits ignored");
  endtask

  task automatic t_lane_isolation;
    run_exp(32'hFFFF_0000, 16'hFFF8, 32'hFFFF_0000, 2'b00, "R1 no leak right");
    run_exp(32'h0000_FFFF, 16'd4, 32'h0000_FFF0, 2'b00, "R1 no leak left");
  endtask

  task automatic t_sweep;
    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h0123, 16'hC000, 16'h4000};
    for (int c = -16; c <= 16; c++) begin
      for (int i = 0; i < 8; i++) begin
        run({vals[i], vals[7 - i]}, 16'(c), "R1 R4 R5 R7 sweep");
      end
    end
  endtask

  initial begin
    t_reset();
    t_known_values();
    t_zero_count();
    t_clamp_edges();
    t_zero_lane();
    t_large_counts();
    t_lane_isolation();
    t_sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule